// File: doc/BRIEF.md
# D-PHY Lane Timing Count Generator

This block turns a link data rate, given in whole megahertz, into the full set of low-power and high-speed timing counts that a D-PHY transmitter needs for its data and clock lanes. Each count is an affine function of the rate with a divide-by-8000 scale. The block packs the counts into four 32-bit timing-control words whose byte lanes a downstream PHY decodes.

A single-cycle start pulse captures the rate and an optional override set. A sequential restoring divider then evaluates the four constant divisions one after another. A one-cycle done pulse marks the moment all four words have been updated. Any field can be forced to a board-chosen byte before packing. A flag reports whether any computed count, before override, did not fit in a byte.

The caller is expected to round the bit rate up to whole megahertz before presenting it. The block does not choose the rate, and it does not drive the PLL or the lane drivers.

Top module: `dphy_timing_gen`

## Requirements
- R1: After reset, all four timing words are zero, and busy, done and overflow are low.
- R2: A start pulse while busy is low captures rateMhz, ovrMask and ovrValue, and busy is high from the next cycle until done. A start pulse while busy is high is ignored: the run in progress completes with the values it captured first.
- R3: With r the captured rate and all divisions truncating, the computed data-lane fields are: lpx = 60r/8000 + 1; hsPrep = (80r + 4000)/8000; hsZero = (170r + 10000)/8000 + 1 - hsPrep; hsTrail = hsPrep + 1.
- R4: The turnaround and exit fields come from lpx: taGo = 4·lpx - 2, taSure = lpx + 2, taGet = 4·lpx, hsExit = 2·lpx + 1. The sync field hsSync is always 1.
- R5: The clock-lane fields are: ckPrep = 70r/8000, ckTrail = ckPrep, ckPost = ckPrep + 8, ckZero = 4·ckTrail, ckExit = 2·ckTrail.
- R6: timeWord0 holds, from its least significant byte upward, lpx, hsPrep, hsZero, hsTrail. timeWord1 holds, from its least significant byte upward, taGo, taSure, taGet, hsExit.
- R7: In timeWord2, bits [7:0] are zero, [15:8] hold hsSync, [23:16] hold ckZero and [31:24] hold ckTrail. In timeWord3, [7:0] hold ckPrep, [15:8] hold ckPost, [23:16] hold ckExit and [31:24] are zero.
- R8: The fields are indexed 0..13 in this order: lpx, hsPrep, hsZero, hsTrail, taGo, taSure, taGet, hsExit, hsSync, ckPrep, ckPost, ckTrail, ckZero, ckExit. When captured ovrMask bit i is 1, the byte ovrValue[8i+7:8i] is packed in place of field i.
- R9: Each field that is not overridden is packed as the low 8 bits of its computed value. overflow is high when any computed field, before override, exceeds 255.
- R10: done is high for exactly one cycle, and the four words and overflow take their new values in that same cycle. The words and overflow do not change again until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only while idle |
| rateMhz | input | RATE_W | Data rate in MHz, rounded up |
| ovrMask | input | 14 | Per-field override enable |
| ovrValue | input | 112 | Override bytes, byte i belongs to field i |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | A computed field exceeded 255 |
| timeWord0 | output | 32 | lpx, hsPrep, hsZero, hsTrail |
| timeWord1 | output | 32 | taGo, taSure, taGet, hsExit |
| timeWord2 | output | 32 | hsSync, ckZero, ckTrail |
| timeWord3 | output | 32 | ckPrep, ckPost, ckExit |

## Verification
A wrong remainder or quotient in the divider is invisible until the next done pulse. At that point it appears as a wrong byte in one of the words, offset in one direction across a whole range of rates. Sweeping every rate from 0 to 1023, plus the rates where a quotient first reaches 64, exposes such an error on the first run whose quotient crosses an integer step. A control error in the step count or the division select shows up either as shifted quotients in every field or as done failing to arrive within one run's latency. An error in holding state shows up as words changing while done is low.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 14;
  localparam int NUM_DIVS   = 4;
  localparam int SCALE_DIV  = 8000;
  localparam int REM_W      = $clog2(SCALE_DIV);

  // field index order, decoded by the override inputs
  localparam int F_LPX     = 0;
  localparam int F_HSPREP  = 1;
  localparam int F_HSZERO  = 2;
  localparam int F_HSTRAIL = 3;
  localparam int F_TAGO    = 4;
  localparam int F_TASURE  = 5;
  localparam int F_TAGET   = 6;
  localparam int F_HSEXIT  = 7;
  localparam int F_HSSYNC  = 8;
  localparam int F_CKPREP  = 9;
  localparam int F_CKPOST  = 10;
  localparam int F_CKTRAIL = 11;
  localparam int F_CKZERO  = 12;
  localparam int F_CKEXIT  = 13;

  // affine coefficients of the four divisions
  localparam int K_LPX_MUL   = 60;
  localparam int K_PREP_MUL  = 80;
  localparam int K_PREP_ADD  = 4000;
  localparam int K_ZERO_MUL  = 170;
  localparam int K_ZERO_ADD  = 10000;
  localparam int K_CKPREP_MUL = 70;

  typedef struct packed {
    logic       capture;
    logic       divInit;
    logic       divStep;
    logic       divStore;
    logic       pack;
    logic [1:0] divSel;
  } dtgStrobe_t;
endpackage

// File: rtl/dtg_ctrl.sv
module dtg_ctrl
  import dtg_pkg::*;
#(
  parameter int STEPS = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output dtgStrobe_t stb,
  output logic       busy,
  output logic       done
);
  localparam int CNT_W = $clog2(STEPS + 1);

  typedef enum logic [2:0] {S_IDLE, S_INIT, S_STEP, S_STORE, S_PACK} state_e;

  state_e            state, stateNxt;
  logic [CNT_W-1:0]  stepCnt;
  logic [1:0]        divSel;

  always_comb begin
    stb        = '0;
    stb.divSel = divSel;
    stateNxt   = state;
    case (state)
      S_IDLE: if (start) begin
        stb.capture = 1'b1;
        stateNxt    = S_INIT;
      end
      S_INIT: begin
        stb.divInit = 1'b1;
        stateNxt    = S_STEP;
      end
      S_STEP: begin
        stb.divStep = 1'b1;
        if (stepCnt == CNT_W'(STEPS - 1)) stateNxt = S_STORE;
      end
      S_STORE: begin
        stb.divStore = 1'b1;
        stateNxt     = (divSel == 2'(NUM_DIVS - 1)) ? S_PACK : S_INIT;
      end
      S_PACK: begin
        stb.pack = 1'b1;
        stateNxt = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      divSel  <= '0;
      done    <= 1'b0;
    end else begin
      state   <= stateNxt;
      done    <= (state == S_PACK);
      stepCnt <= (state == S_STEP) ? stepCnt + 1'b1 : '0;
      if (stb.capture)         divSel <= '0;
      else if (stb.divStore)   divSel <= divSel + 1'b1;
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/dtg_datapath.sv
module dtg_datapath
  import dtg_pkg::*;
#(
  parameter int RATE_W = 16,
  parameter int NUM_W  = RATE_W + 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dtgStrobe_t                    stb,
  input  logic [RATE_W-1:0]             rateMhz,
  input  logic [NUM_FIELDS-1:0]         ovrMask,
  input  logic [NUM_FIELDS*FIELD_W-1:0] ovrValue,
  output logic [31:0]                   word0,
  output logic [31:0]                   word1,
  output logic [31:0]                   word2,
  output logic [31:0]                   word3,
  output logic                          overflow
);
  localparam int FW = NUM_W + 3;

  logic [RATE_W-1:0]             rateQ;
  logic [NUM_FIELDS-1:0]         maskQ;
  logic [NUM_FIELDS*FIELD_W-1:0] valQ;
  logic [NUM_W-1:0]              numSh, quo, numSel, rateExt;
  logic [REM_W-1:0]              rem;
  logic [REM_W:0]                trial;
  logic [NUM_W-1:0]              qArr [NUM_DIVS];
  logic [FW-1:0]                 fld  [NUM_FIELDS];
  logic [FIELD_W-1:0]            fByte [NUM_FIELDS];
  logic [NUM_FIELDS-1:0]         tooBig;
  logic [FW-1:0]                 lpxW;

  assign rateExt = NUM_W'(rateQ);

  always_comb begin
    case (stb.divSel)
      2'd0:    numSel = NUM_W'(K_LPX_MUL) * rateExt;
      2'd1:    numSel = NUM_W'(K_PREP_MUL) * rateExt + NUM_W'(K_PREP_ADD);
      2'd2:    numSel = NUM_W'(K_ZERO_MUL) * rateExt + NUM_W'(K_ZERO_ADD);
      default: numSel = NUM_W'(K_CKPREP_MUL) * rateExt;
    endcase
  end

  assign trial = {rem, numSh[NUM_W-1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateQ <= '0;
      maskQ <= '0;
      valQ  <= '0;
      numSh <= '0;
      rem   <= '0;
      quo   <= '0;
      for (int i = 0; i < NUM_DIVS; i++) qArr[i] <= '0;
    end else begin
      if (stb.capture) begin
        rateQ <= rateMhz;
        maskQ <= ovrMask;
        valQ  <= ovrValue;
      end
      if (stb.divInit) begin
        numSh <= numSel;
        rem   <= '0;
        quo   <= '0;
      end else if (stb.divStep) begin
        numSh <= numSh << 1;
        if (trial >= (REM_W+1)'(SCALE_DIV)) begin
          rem <= REM_W'(trial - (REM_W+1)'(SCALE_DIV));
          quo <= {quo[NUM_W-2:0], 1'b1};
        end else begin
          rem <= trial[REM_W-1:0];
          quo <= {quo[NUM_W-2:0], 1'b0};
        end
      end
      if (stb.divStore) qArr[stb.divSel] <= quo;
    end
  end

  // field arithmetic
  assign lpxW = FW'(qArr[0]) + FW'(1);
  always_comb begin
    fld[F_LPX]     = lpxW;
    fld[F_HSPREP]  = FW'(qArr[1]);
    fld[F_HSZERO]  = FW'(qArr[2]) + FW'(1) - FW'(qArr[1]);
    fld[F_HSTRAIL] = FW'(qArr[1]) + FW'(1);
    fld[F_TAGO]    = (lpxW << 2) - FW'(2);
    fld[F_TASURE]  = lpxW + FW'(2);
    fld[F_TAGET]   = lpxW << 2;
    fld[F_HSEXIT]  = (lpxW << 1) + FW'(1);
    fld[F_HSSYNC]  = FW'(1);
    fld[F_CKPREP]  = FW'(qArr[3]);
    fld[F_CKPOST]  = FW'(qArr[3]) + FW'(8);
    fld[F_CKTRAIL] = FW'(qArr[3]);
    fld[F_CKZERO]  = FW'(qArr[3]) << 2;
    fld[F_CKEXIT]  = FW'(qArr[3]) << 1;
  end

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
    assign fByte[gi]  = maskQ[gi] ? valQ[gi*FIELD_W +: FIELD_W] : fld[gi][FIELD_W-1:0];
    assign tooBig[gi] = |fld[gi][FW-1:FIELD_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      word0    <= '0;
      word1    <= '0;
      word2    <= '0;
      word3    <= '0;
      overflow <= 1'b0;
    end else if (stb.pack) begin
      word0    <= {fByte[F_HSTRAIL], fByte[F_HSZERO], fByte[F_HSPREP], fByte[F_LPX]};
      word1    <= {fByte[F_HSEXIT], fByte[F_TAGET], fByte[F_TASURE], fByte[F_TAGO]};
      word2    <= {fByte[F_CKTRAIL], fByte[F_CKZERO], fByte[F_HSSYNC], 8'h00};
      word3    <= {8'h00, fByte[F_CKEXIT], fByte[F_CKPOST], fByte[F_CKPREP]};
      overflow <= |tooBig;
    end
  end
endmodule

// File: rtl/dphy_timing_gen.sv
module dphy_timing_gen
  import dtg_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [RATE_W-1:0]             rateMhz,
  input  logic [NUM_FIELDS-1:0]         ovrMask,
  input  logic [NUM_FIELDS*FIELD_W-1:0] ovrValue,
  output logic                          busy,
  output logic                          done,
  output logic                          overflow,
  output logic [31:0]                   timeWord0,
  output logic [31:0]                   timeWord1,
  output logic [31:0]                   timeWord2,
  output logic [31:0]                   timeWord3
);
  localparam int NUM_W = RATE_W + 8;

  dtgStrobe_t stb;

  dtg_ctrl #(.STEPS(NUM_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .stb(stb), .busy(busy), .done(done)
  );

  dtg_datapath #(.RATE_W(RATE_W), .NUM_W(NUM_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rateMhz(rateMhz), .ovrMask(ovrMask), .ovrValue(ovrValue),
    .word0(timeWord0), .word1(timeWord1), .word2(timeWord2), .word3(timeWord3),
    .overflow(overflow)
  );
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        overflow,
  input logic [31:0] w0,
  input logic [31:0] w1,
  input logic [31:0] w2,
  input logic [31:0] w3
);
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_hold_outputs_r10: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(w0) && $stable(w1) && $stable(w2) && $stable(w3) && $stable(overflow)));

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
endmodule

bind dphy_timing_gen dtg_checker u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .overflow(overflow), .w0(timeWord0), .w1(timeWord1), .w2(timeWord2), .w3(timeWord3)
);

// File: tb/sim_dphy_timing_gen.sv
module sim_dphy_timing_gen;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [15:0]  rateMhz = '0;
  logic [13:0]  ovrMask = '0;
  logic [111:0] ovrValue = '0;
  logic         busy, done, overflow;
  logic [31:0]  timeWord0, timeWord1, timeWord2, timeWord3;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  logic [31:0] e0, e1, e2, e3;
  logic        eOv;

  always #2.5 clk = ~clk;

  dphy_timing_gen u0 (
    .clk(clk), .rstN(rstN), .start(start), .rateMhz(rateMhz),
    .ovrMask(ovrMask), .ovrValue(ovrValue), .busy(busy), .done(done),
    .overflow(overflow), .timeWord0(timeWord0), .timeWord1(timeWord1),
    .timeWord2(timeWord2), .timeWord3(timeWord3)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected words from the requirement formulas
  task automatic model(input int r, input logic [13:0] m, input logic [111:0] v);
    int f [14];
    logic [7:0] b [14];
    int lpx, prep, ck;
    lpx  = 60 * r / 8000 + 1;
    prep = (80 * r + 4000) / 8000;
    ck   = 70 * r / 8000;
    f[0] = lpx;  f[1] = prep;  f[2] = (170 * r + 10000) / 8000 + 1 - prep;  f[3] = prep + 1;
    f[4] = 4 * lpx - 2;  f[5] = lpx + 2;  f[6] = 4 * lpx;  f[7] = 2 * lpx + 1;  f[8] = 1;
    f[9] = ck;  f[10] = ck + 8;  f[11] = ck;  f[12] = 4 * ck;  f[13] = 2 * ck;
    eOv = 1'b0;
    for (int i = 0; i < 14; i++) begin
      b[i] = m[i] ? v[i*8 +: 8] : f[i][7:0];
      if (f[i] > 255) eOv = 1'b1;
    end
    e0 = {b[3], b[2], b[1], b[0]};
    e1 = {b[7], b[6], b[5], b[4]};
    e2 = {b[11], b[12], b[8], 8'h00};
    e3 = {8'h00, b[13], b[10], b[9]};
  endtask

  task automatic waitDone(output bit ok);
    int n = 0;
    ok = 1;
    while (!done) begin
      @(negedge clk);
      n++;
      if (n > 400) begin ok = 0; break; end
    end
  endtask

  task automatic checkWords(input string tag);
    chk({tag, " R3 R6 word0"}, timeWord0, e0);
    chk({tag, " R4 R6 word1"}, timeWord1, e1);
    chk({tag, " R5 R7 word2"}, timeWord2, e2);
    chk({tag, " R5 R7 word3"}, timeWord3, e3);
    chk({tag, " R9 overflow"}, {31'd0, overflow}, {31'd0, eOv});
  endtask

  task automatic runOp(input int r, input logic [13:0] m, input logic [111:0] v, input string tag);
    bit ok;
    @(negedge clk);
    rateMhz = 16'(r); ovrMask = m; ovrValue = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R2 busy after start"}, {31'd0, busy}, 32'd1);
    waitDone(ok);
    chk({tag, " R10 done arrives"}, {31'd0, ok}, 32'd1);
    model(r, m, v);
    checkWords(tag);
    @(negedge clk);
    chk({tag, " R10 done single"}, {31'd0, done}, 32'd0);
  endtask

  function automatic logic [111:0] patVals(input int seed);
    logic [111:0] x;
    for (int i = 0; i < 14; i++) x[i*8 +: 8] = 8'(seed + 37 * i);
    return x;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit ok;
    logic [31:0] h0, h1, h2, h3;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 word0", timeWord0, 0); chk("R1 word1", timeWord1, 0);
    chk("R1 word2", timeWord2, 0); chk("R1 word3", timeWord3, 0);
    chk("R1 flags", {29'd0, busy, done, overflow}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // sweep of low rates, no overrides
    for (int r = 0; r < 1024; r++) runOp(r, '0, '0, "sweep");
    // coarse sweep of the upper range
    for (int r = 1024; r < 65536; r += 1021) runOp(r, '0, '0, "coarse");
    // R9 overflow boundary
    runOp(7314, '0, '0, "R9 below");
    runOp(7315, '0, '0, "R9 above");
    runOp(65535, '0, '0, "R9 max");
    // R8 override patterns
    runOp(700, 14'h3FFF, patVals(5), "R8 all");
    runOp(700, 14'h2AAA, patVals(91), "R8 alt");
    runOp(2500, 14'h1555, patVals(200), "R8 alt2");
    runOp(65535, 14'h0001, patVals(3), "R8 R9 ovr with overflow");
    runOp(65535, 14'h3FFF, patVals(17), "R8 R9 full ovr");

    // R2 start during busy is ignored
    @(negedge clk);
    rateMhz = 16'd500; ovrMask = '0; ovrValue = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rateMhz = 16'd9000; ovrMask = 14'h3FFF; ovrValue = patVals(77); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(ok);
    chk("R2 ignored start done", {31'd0, ok}, 32'd1);
    model(500, '0, '0);
    checkWords("R2 ignored start");
    @(negedge clk);
    chk("R2 idle after ignored start", {30'd0, busy, done}, 32'd0);

    // R10 outputs hold while idle with inputs changing
    h0 = timeWord0; h1 = timeWord1; h2 = timeWord2; h3 = timeWord3;
    for (int k = 0; k < 20; k++) begin
      rateMhz = 16'(k * 999); ovrMask = 14'(k * 313); ovrValue = patVals(k);
      @(negedge clk);
    end
    chk("R10 hold word0", timeWord0, h0); chk("R10 hold word1", timeWord1, h1);
    chk("R10 hold word2", timeWord2, h2); chk("R10 hold word3", timeWord3, h3);
    chk("R10 no done while idle", {31'd0, done}, 32'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule